// File: doc/BRIEF.md
# Edge-Selectable Input Capture Timer

This block holds a 16-bit up-counter that advances on a count-enable pulse derived from the base clock by a selectable power-of-two divider (divide by 2 up to divide by 128). An external trigger pin is brought into the base-clock domain through a two-flop synchronizer. Each qualifying transition on the synchronized pin copies the counter into one of two capture registers and raises a one-cycle interrupt pulse.

Software picks which transitions qualify: none, rising, falling or both. A routing bit chooses the destination register. With both transitions enabled, the difference between two consecutive captures is the high or low time of the input. With a single transition enabled, the difference is the input period. Both are measured in counter ticks.

Top module: `cap_timer_top`

## Requirements
- R1: While `rst` is high, and after it falls, `count_o`, `cap0_o` and `cap1_o` read 0 and `cap_irq_o` reads 0 until the first tick or capture.
- R2: While `en_i` is high, `count_o` grows by exactly one every 2^(`div_sel_i`+1) base-clock cycles. Codes 0..6 give /2../128, and code 7 behaves as /128. Any step of the counter is +1, modulo 2^16.
- R3: While `en_i` is low, `count_o` holds its value and no capture or interrupt occurs. Raising `en_i` restarts the divider from zero.
- R4: `edge_sel_i` encodes the qualifying transition: 2'b00 none, 2'b01 low-to-high, 2'b10 high-to-low, 2'b11 either.
- R5: `dest_sel_i`=0 writes the capture to `cap0_o` and `dest_sel_i`=1 writes it to `cap1_o`. The other register keeps its value.
- R6: The stored value is the counter value before any increment that lands on the same clock edge. That is the `count_o` value seen in the cycle before the capture edge.
- R7: A qualifying pin transition driven before clock edge k is captured on edge k+2. `cap_irq_o` is high for exactly the one cycle that follows, and a capture register changes only together with `cap_irq_o`.
- R8: With either-transition mode, the two captures around a high pulse of H base cycles differ by H/2^(`div_sel_i`+1) ticks. With a single transition selected, captures one period P apart differ by P/2^(`div_sel_i`+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Counter and capture enable |
| div_sel_i | input | 3 | Count-clock divider code |
| trig_i | input | 1 | Asynchronous capture trigger pin |
| edge_sel_i | input | 2 | Qualifying transition code |
| dest_sel_i | input | 1 | Capture destination select |
| count_o | output | 16 | Current counter value |
| cap0_o | output | 16 | Capture register 0 |
| cap1_o | output | 16 | Capture register 1 |
| cap_irq_o | output | 1 | One-cycle capture interrupt |

## Verification
Every cycle, the assertions check four things. The counter only ever holds or steps by one. It freezes when disabled. Disabled or "none" mode never raises the interrupt. A capture touches at most one register, only with the interrupt, and stores the previous cycle's count into the selected register. The bench scenarios are needed for the rest. Only they can show the exact divider rate for each code, including the clamped code, and the transition-to-capture latency. They also show the per-mode qualification of each pin transition and the pulse-width and period differences between captures.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/cap_timer_prescale.sv
module cap_timer_prescale #(
  parameter int STAGES = 7,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int MAX_SEL = STAGES - 1;

  logic [STAGES-1:0] div_q;
  logic [STAGES-1:0] mask;
  logic [SEL_W-1:0]  sel_eff;

  // codes beyond the last stage saturate at the slowest division
  always_comb begin
    if (int'(sel_i) > MAX_SEL) sel_eff = SEL_W'(MAX_SEL);
    else                       sel_eff = sel_i;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_mask
    assign mask[g] = (int'(sel_eff) >= g);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  // one pulse each time the selected low bits are all ones
  assign tick_o = en_i && ((div_q & mask) == mask);
endmodule

// File: rtl/cap_timer_counter.sv
module cap_timer_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst)         count_o <= '0;
    else if (tick_i) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/cap_timer_edge.sv
module cap_timer_edge
  import cap_timer_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  edge_mode_e mode_i,
  output logic       hit_o
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            lvl;
  logic            rise;
  logic            fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign lvl  = sync_q[SYNC-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_timer_bank.sv
module cap_timer_bank #(
  parameter int W     = 16,
  parameter int NREG  = 2,
  parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic [W-1:0]     value_i,
  output logic [W-1:0]     cap_o [NREG],
  output logic             irq_o
);
  logic [NREG-1:0] we;

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign we[g] = hit_i && (sel_i == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) cap_o[i] <= '0;
      irq_o <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (we[i]) cap_o[i] <= value_i;
      irq_o <= hit_i;
    end
  end
endmodule

// File: rtl/cap_timer_top.sv
module cap_timer_top
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_STAGES  = 7,
  parameter int DIV_SEL_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 trig_i,
  input  logic [1:0]           edge_sel_i,
  input  logic                 dest_sel_i,
  output logic [CNT_W-1:0]     count_o,
  output logic [CNT_W-1:0]     cap0_o,
  output logic [CNT_W-1:0]     cap1_o,
  output logic                 cap_irq_o
);
  localparam int NREG = 2;

  logic             tick;
  logic             edge_hit;
  logic [CNT_W-1:0] caps [NREG];

  cap_timer_prescale #(.STAGES(DIV_STAGES), .SEL_W(DIV_SEL_W)) u_psc (
    .clk(clk), .rst(rst), .en_i(en_i), .sel_i(div_sel_i), .tick_o(tick)
  );

  cap_timer_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .count_o(count_o)
  );

  cap_timer_edge #(.SYNC(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pin_i(trig_i),
    .mode_i(edge_mode_e'(edge_sel_i)), .hit_o(edge_hit)
  );

  cap_timer_bank #(.W(CNT_W), .NREG(NREG), .IDX_W(1)) u_bank (
    .clk(clk), .rst(rst), .hit_i(edge_hit && en_i), .sel_i(dest_sel_i),
    .value_i(count_o), .cap_o(caps), .irq_o(cap_irq_o)
  );

  assign cap0_o = caps[0];
  assign cap1_o = caps[1];
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W     = 16,
  parameter int DIV_SEL_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en_i,
  input logic [DIV_SEL_W-1:0] div_sel_i,
  input logic                 trig_i,
  input logic [1:0]           edge_sel_i,
  input logic                 dest_sel_i,
  input logic [CNT_W-1:0]     count_o,
  input logic [CNT_W-1:0]     cap0_o,
  input logic [CNT_W-1:0]     cap1_o,
  input logic                 cap_irq_o
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)); // R2
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (count_o == $past(count_o))); // R3
  AST_NO_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !cap_irq_o); // R3
  AST_NONE_MODE: assert property (@(posedge clk) disable iff (rst)
    (edge_sel_i == 2'b00) |=> !cap_irq_o); // R4
  AST_ONE_DEST: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !((cap0_o != $past(cap0_o)) && (cap1_o != $past(cap1_o)))); // R5
  AST_CAP_VAL0: assert property (@(posedge clk) disable iff (rst)
    (cap_irq_o && !$past(dest_sel_i)) |-> (cap0_o == $past(count_o))); // R6
  AST_CAP_VAL1: assert property (@(posedge clk) disable iff (rst)
    (cap_irq_o && $past(dest_sel_i)) |-> (cap1_o == $past(count_o))); // R6
  AST_CHG_IRQ: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((cap0_o != $past(cap0_o)) || (cap1_o != $past(cap1_o))) -> cap_irq_o)); // R7
endmodule

bind cap_timer_top cap_timer_chk #(.CNT_W(CNT_W), .DIV_SEL_W(DIV_SEL_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .div_sel_i(div_sel_i), .trig_i(trig_i),
  .edge_sel_i(edge_sel_i), .dest_sel_i(dest_sel_i), .count_o(count_o),
  .cap0_o(cap0_o), .cap1_o(cap1_o), .cap_irq_o(cap_irq_o)
);

// File: tb/test_cap_timer_top.sv
`timescale 1ns/1ps
module test_cap_timer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_i = 1'b0;
  logic [2:0]  div_sel_i = 3'd0;
  logic        trig_i = 1'b0;
  logic [1:0]  edge_sel_i = 2'b00;
  logic        dest_sel_i = 1'b0;
  logic [15:0] count_o, cap0_o, cap1_o;
  logic        cap_irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cap_timer_top i_cap_timer_top (
    .clk(clk), .rst(rst), .en_i(en_i), .div_sel_i(div_sel_i), .trig_i(trig_i),
    .edge_sel_i(edge_sel_i), .dest_sel_i(dest_sel_i), .count_o(count_o),
    .cap0_o(cap0_o), .cap1_o(cap1_o), .cap_irq_o(cap_irq_o)
  );

  // entries: {edge code, destination, new pin level, capture expected}
  localparam logic [4:0] VEC [10] = '{
    5'b01_0_1_1, 5'b01_0_0_0, 5'b10_1_1_0, 5'b10_1_0_1, 5'b11_0_1_1,
    5'b11_1_0_1, 5'b00_0_1_0, 5'b00_1_0_0, 5'b11_1_1_1, 5'b01_1_0_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive a level at a falling edge; return count seen before the capture edge
  task automatic drive_pin(input logic lvl, output logic [15:0] pre);
    @(negedge clk); trig_i = lvl;
    @(posedge clk); @(posedge clk);
    @(negedge clk); pre = count_o;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] pre, a0, b0, c0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", count_o, 0);
    check("R1 irq in reset", cap_irq_o, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 cap0 after reset", cap0_o, 0);
    check("R1 cap1 after reset", cap1_o, 0);
    check("R1 count after reset", count_o, 0);
    en_i = 1'b1;

    // table walk: qualification and routing
    foreach (VEC[i]) begin
      edge_sel_i = VEC[i][4:3];
      dest_sel_i = VEC[i][2];
      a0 = cap0_o; b0 = cap1_o;
      drive_pin(VEC[i][1], pre);
      check("R4/R7 irq for table entry", cap_irq_o, VEC[i][0]);
      if (VEC[i][0] && !VEC[i][2]) begin
        check("R6 cap0 value", cap0_o, pre);
        check("R5 cap1 untouched", cap1_o, b0);
      end else if (VEC[i][0]) begin
        check("R6 cap1 value", cap1_o, pre);
        check("R5 cap0 untouched", cap0_o, a0);
      end else begin
        check("R4 cap0 unchanged", cap0_o, a0);
        check("R4 cap1 unchanged", cap1_o, b0);
      end
      @(negedge clk);
      check("R7 irq single cycle", cap_irq_o, 0);
    end

    // pulse width, /2: high for 40 cycles -> 20 ticks
    div_sel_i = 3'd0; edge_sel_i = 2'b11; dest_sel_i = 1'b0;
    trig_i = 1'b0; repeat (6) @(negedge clk);
    trig_i = 1'b1;
    repeat (5) @(negedge clk); dest_sel_i = 1'b1;
    repeat (35) @(negedge clk); trig_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R8 pulse width ticks", 16'(cap1_o - cap0_o), 20);

    // period, /4: single rising edge, period 64 cycles -> 16 ticks
    div_sel_i = 3'd1; edge_sel_i = 2'b01; dest_sel_i = 1'b0;
    repeat (4) @(negedge clk);
    trig_i = 1'b1;
    repeat (5) @(negedge clk); dest_sel_i = 1'b1;
    repeat (27) @(negedge clk); trig_i = 1'b0;
    repeat (32) @(negedge clk); trig_i = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 period ticks", 16'(cap1_o - cap0_o), 16);
    trig_i = 1'b0; repeat (6) @(negedge clk);

    // divider rates
    div_sel_i = 3'd3; @(negedge clk); c0 = count_o;
    repeat (160) @(negedge clk);
    check("R2 /16 rate", 16'(count_o - c0), 10);
    div_sel_i = 3'd6; @(negedge clk); c0 = count_o;
    repeat (256) @(negedge clk);
    check("R2 /128 rate", 16'(count_o - c0), 2);
    div_sel_i = 3'd7; @(negedge clk); c0 = count_o;
    repeat (384) @(negedge clk);
    check("R2 code 7 clamps to /128", 16'(count_o - c0), 3);

    // disabled: counter frozen, no capture
    en_i = 1'b0; edge_sel_i = 2'b11; div_sel_i = 3'd0;
    @(negedge clk); c0 = count_o; a0 = cap0_o; b0 = cap1_o;
    drive_pin(1'b1, pre);
    check("R3 no irq when disabled", cap_irq_o, 0);
    check("R3 cap1 held when disabled", cap1_o, b0);
    check("R3 cap0 held when disabled", cap0_o, a0);
    repeat (40) @(negedge clk);
    check("R3 counter held", count_o, c0);
    // re-enable: divider restarts, first tick after two cycles
    en_i = 1'b1; @(negedge clk);
    check("R3 no tick first cycle", count_o, c0);
    @(negedge clk);
    check("R3 tick second cycle", count_o, 16'(c0 + 1));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule